// File: doc/BRIEF.md
# MDIO Management Master (Clause 22 / Clause 45)

This block is a station-management master for Ethernet PHYs. Software issues exactly one MDIO frame per write to a 32-bit command register. The register carries a go bit, the two start-of-frame bits, the two operation bits, a 5-bit port address, a 5-bit register or device address, and a 16-bit payload. The start and operation fields are placed on the wire unchanged. Because of this, one serial engine produces Clause 22 reads and writes, and also Clause 45 address, write and read frames, with no logic that depends on the clause.

The engine first sends a 32-bit all-ones preamble. It then sends the header, the turnaround and 16 data bits, MSB first, on a divided management clock. On write and address frames the master drives MDIO for the whole frame. On read frames it releases MDIO from the first turnaround bit to the end of the frame and shifts in the PHY's data on each rising MDC edge. At completion the read result is placed in the payload field. A Clause 45 access takes two commands: an address frame that loads the PHY's register pointer for one device, then a write or read frame that uses the same port and device fields. Software waits for the go bit to clear before it issues each command.

Top module: `mdio_master`

## Requirements
- R1: After reset the command register reads all zeros, busy is low, MDC is low and MDIO is not driven.
- R2: A command write with bit 31 set, accepted while idle, starts one frame. Bit 31 reads back as 1 (busy) until the frame ends, and hardware then clears it.
- R3: A command write that arrives while a frame is running is ignored. The register contents are unchanged and no extra frame is produced.
- R4: A frame is 64 MDC periods: 32 ones, then the start code (bits 17:16), the opcode (bits 19:18), the port (bits 24:20), the register/device field (bits 29:25), two turnaround bits and the 16-bit payload (bits 15:0), each field sent MSB first. Start code 1 selects Clause 22 framing and 0 selects Clause 45 framing.
- R5: Each MDC phase lasts mdc_half+1 system clocks, so the MDC period is 2*(mdc_half+1) clocks. MDC is high only during a frame. mdc_half must be at least 1.
- R6: MDIO output changes only one system clock after a falling MDC edge, never while MDC is high.
- R7: Opcodes 0 (Clause 45 address) and 1 (write) drive MDIO for all 64 bits, with turnaround 1 then 0, followed by the payload.
- R8: Opcodes 2 (Clause 22 read) and 3 (Clause 45 read) release MDIO from the first turnaround bit onward. The last 16 bits are sampled on rising MDC edges, and at completion the 16 bits are written into bits 15:0.
- R9: A Clause 45 address frame followed by a write, and later an address frame followed by a read to the same port and device, returns the written data. Separate register pointers do not disturb each other.
- R10: When a write or address frame completes, the payload field still holds the value software wrote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mdc_half | input | DIV_W | MDC phase length minus one, in system clocks (at least 1) |
| cmd_wr | input | 1 | Write strobe for the command register |
| cmd_wdata | input | 32 | Command word to write |
| cmd_rdata | output | 32 | Command register contents (go bit, fields, read result) |
| busy | output | 1 | Frame in progress (mirror of bit 31) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO line value as seen at the pin |

## Verification
The assertions assume that mdc_half is at least 1 and stays stable during a frame. They also assume that the PHY drives MDIO only while the master has released it. The bench sets mdc_half only between frames, to 3 or 1. Its behavioural PHY drives the line only from the second turnaround bit of a read, on falling MDC edges, and it counts any overlap with the master's output enable. Commands that arrive during a frame are sent on purpose, to exercise R3.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int PRE_BITS   = 32;
  localparam int TA_POS     = 46;
  localparam int DATA_POS   = 48;
  localparam int IDX_W      = $clog2(FRAME_BITS);

  localparam int GO_BIT   = 31;
  localparam int DEV_LSB  = 25;
  localparam int PORT_LSB = 20;
  localparam int OP_LSB   = 18;
  localparam int ST_LSB   = 16;

  typedef enum logic [1:0] {
    OP_C45_ADDR = 2'd0,
    OP_WRITE    = 2'd1,
    OP_C22_READ = 2'd2,
    OP_C45_READ = 2'd3
  } mdio_op_e;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             mdc_q, mdc_d;
  logic             wrap;

  assign wrap      = run && (cnt_q == half);
  assign rise_tick = wrap && !mdc_q;
  assign fall_tick = wrap && mdc_q;
  assign mdc       = mdc_q;

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      mdc_d = !mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [FRAME_BITS-1:0] frame,
  input  logic                  rd_frame,
  input  logic                  rise_tick,
  input  logic                  fall_tick,
  input  logic                  mdio_i,
  output logic                  mdio_o,
  output logic                  mdio_oe,
  output logic                  done,
  output logic [15:0]           rd_data
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_POS);
  localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(DATA_POS);

  logic             active_q, active_d;
  logic [IDX_W-1:0] idx_q, idx_d, nxt;
  logic             fall_d_q;
  logic             out_q, out_d;
  logic             oe_q, oe_d;
  logic [15:0]      sh_q, sh_d;
  logic             adv_en, smp_en;

  assign nxt     = idx_q + 1'b1;
  assign adv_en  = active_q && fall_d_q;
  assign smp_en  = active_q && rise_tick && (idx_q >= DATA_IDX);
  assign done    = adv_en && (idx_q == LAST_IDX);
  assign mdio_o  = out_q;
  assign mdio_oe = oe_q;
  assign rd_data = sh_q;

  always_comb begin
    active_d = active_q;
    idx_d    = idx_q;
    out_d    = out_q;
    oe_d     = oe_q;
    sh_d     = sh_q;
    if (start) begin
      active_d = 1'b1;
      idx_d    = '0;
      out_d    = 1'b1;
      oe_d     = 1'b1;
    end else if (adv_en) begin
      if (idx_q == LAST_IDX) begin
        active_d = 1'b0;
        out_d    = 1'b1;
        oe_d     = 1'b0;
      end else begin
        idx_d = nxt;
        oe_d  = !(rd_frame && (nxt >= TA_IDX));
        out_d = oe_d ? frame[LAST_IDX - nxt] : 1'b1;
      end
    end
    if (smp_en) begin
      sh_d = {sh_q[14:0], mdio_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      fall_d_q <= 1'b0;
      out_q    <= 1'b1;
      oe_q     <= 1'b0;
      sh_q     <= '0;
    end else begin
      active_q <= active_d;
      idx_q    <= idx_d;
      fall_d_q <= fall_tick;
      out_q    <= out_d;
      oe_q     <= oe_d;
      sh_q     <= sh_d;
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] mdc_half,
  input  logic             cmd_wr,
  input  logic [31:0]      cmd_wdata,
  output logic [31:0]      cmd_rdata,
  output logic             busy,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);
  logic [1:0]            rst_sync_q;
  logic                  rst_int_n;
  logic [31:0]           cmd_q, cmd_d;
  logic                  accept, start, done, rise_tick, fall_tick, rd_frame;
  logic [15:0]           rd_data;
  logic [FRAME_BITS-1:0] frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign busy      = cmd_q[GO_BIT];
  assign cmd_rdata = cmd_q;
  assign accept    = cmd_wr && !busy;
  assign start     = accept && cmd_wdata[GO_BIT];
  assign rd_frame  = cmd_q[OP_LSB+1];

  assign frame = {{PRE_BITS{1'b1}},
                  cmd_q[ST_LSB +: 2], cmd_q[OP_LSB +: 2],
                  cmd_q[PORT_LSB +: 5], cmd_q[DEV_LSB +: 5],
                  2'b10, cmd_q[15:0]};

  always_comb begin
    cmd_d = cmd_q;
    if (accept) begin
      cmd_d = cmd_wdata;
    end else if (done) begin
      cmd_d[GO_BIT] = 1'b0;
      if (rd_frame) cmd_d[15:0] = rd_data;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) cmd_q <= '0;
    else            cmd_q <= cmd_d;
  end

  mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .run       (busy),
    .half      (mdc_half),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mdio_frame_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (start),
    .frame     (frame),
    .rd_frame  (rd_frame),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .mdio_i    (mdio_i),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .done      (done),
    .rd_data   (rd_data)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        busy,
  input logic [31:0] cmd_rdata
);
  AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc); // R5

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe); // R2

  AST_CHANGE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_o != $past(mdio_o)) |-> (!$past(mdc, 1) && $past(mdc, 2))); // R6

  AST_CMD_HELD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cmd_rdata)); // R3

  AST_READ_NO_DRIVE_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_rdata[19] && $fell(mdio_oe)) |=> !mdio_oe); // R8
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mdc       (mdc),
  .mdio_o    (mdio_o),
  .mdio_oe   (mdio_oe),
  .busy      (busy),
  .cmd_rdata (cmd_rdata)
);

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W      = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [DIV_W-1:0] mdc_half;
  logic             cmd_wr;
  logic [31:0]      cmd_wdata;
  logic [31:0]      cmd_rdata;
  logic             busy, mdc, mdio_o, mdio_oe;
  logic             phy_oe, phy_o;
  logic             mdio_line;

  assign mdio_line = mdio_oe ? mdio_o : (phy_oe ? phy_o : 1'b1);

  mdio_master #(.DIV_W(DIV_W)) u_mdio_master (
    .clk(clk), .rst_n(rst_n), .mdc_half(mdc_half), .cmd_wr(cmd_wr),
    .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata), .busy(busy), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_line)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // scoreboard queues
  logic [15:0] exp_q[$];
  string       tag_q[$];

  initial begin
    wait (rst_n === 1'b1);
    forever begin
      @(negedge busy);
      @(negedge clk);
      if (exp_q.size() == 0) begin
        check(0, "R3", "completion with nothing expected", cmd_rdata, 0);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(cmd_rdata[15:0] == e, t, "payload at completion", {16'h0, cmd_rdata[15:0]}, {16'h0, e});
        check(cmd_rdata[31] == 1'b0, "R2", "go bit cleared", {31'h0, cmd_rdata[31]}, 0);
      end
    end
  end

  // side monitors
  int mdc_rises = 0;
  int wr_gap = 0;
  int edge_viol = 0;
  logic prev_out = 1'b1;
  logic prev_mdc = 1'b0;
  always @(posedge mdc) mdc_rises++;
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (busy && !mdio_oe && !cmd_rdata[19]) wr_gap++;
      if (mdio_o != prev_out && (mdc || prev_mdc)) edge_viol++;
    end
    prev_out = mdio_o;
    prev_mdc = mdc;
  end

  // behavioural PHY
  logic [15:0] c22_regs[int];
  logic [15:0] mmd_ptr[int];
  logic [15:0] mmd_regs[int];
  int          frames_seen = 0;
  int          conflicts = 0;
  logic [1:0]  h_st, h_op, h_ta;
  logic [4:0]  h_port, h_dev;
  logic [15:0] h_data;

  task automatic phy_frame();
    int ones;
    logic [12:0] hdr;
    logic [17:0] tail;
    logic [15:0] rv;
    int k22, kp, km;
    ones = 0;
    forever begin
      @(posedge mdc);
      if (mdio_line) ones++;
      else if (ones >= 32) break;
      else ones = 0;
    end
    for (int i = 0; i < 13; i++) begin
      @(posedge mdc);
      hdr = {hdr[11:0], mdio_line};
    end
    h_st   = {1'b0, hdr[12]};
    h_op   = hdr[11:10];
    h_port = hdr[9:5];
    h_dev  = hdr[4:0];
    k22 = {h_port, h_dev};
    kp  = {h_port, h_dev};
    km  = 0;
    if (mmd_ptr.exists(kp)) km = {h_port, h_dev, mmd_ptr[kp]};
    if (h_op[1]) begin
      if (h_st == 2'b01) rv = c22_regs.exists(k22) ? c22_regs[k22] : 16'hFFFF;
      else               rv = mmd_regs.exists(km) ? mmd_regs[km] : 16'hFFFF;
      @(negedge mdc);
      @(negedge mdc);
      phy_oe = 1'b1; phy_o = 1'b0;
      #1 if (mdio_oe) conflicts++;
      for (int i = 15; i >= 0; i--) begin
        @(negedge mdc);
        phy_o = rv[i];
        #1 if (mdio_oe) conflicts++;
      end
      @(negedge mdc);
      phy_oe = 1'b0;
    end else begin
      for (int i = 0; i < 18; i++) begin
        @(posedge mdc);
        tail = {tail[16:0], mdio_line};
      end
      h_ta   = tail[17:16];
      h_data = tail[15:0];
      if (h_st == 2'b01 && h_op == 2'd1) c22_regs[k22] = h_data;
      else if (h_st == 2'b00 && h_op == 2'd0) mmd_ptr[kp] = h_data;
      else if (h_st == 2'b00 && h_op == 2'd1) mmd_regs[{h_port, h_dev, mmd_ptr[kp]}] = h_data;
    end
    frames_seen++;
  endtask

  initial begin
    phy_oe = 1'b0;
    phy_o  = 1'b1;
    wait (rst_n === 1'b1);
    forever phy_frame();
  end

  function automatic logic [31:0] mk(input logic [4:0] dev, input logic [4:0] port,
                                     input logic [1:0] op, input logic [1:0] st,
                                     input logic [15:0] data);
    return {1'b1, 1'b0, dev, port, op, st, data};
  endfunction

  task automatic issue(input logic [31:0] cmd, input logic [15:0] exp, input string tag);
    while (busy) @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    cmd_wdata = cmd;
    cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
    @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic measure_period(input int exp_clks, input string tag);
    time t0, t1;
    @(posedge mdc); t0 = $time;
    @(posedge mdc); t1 = $time;
    check((t1 - t0) == exp_clks * CLK_PERIOD, tag, "MDC period",
          32'((t1 - t0) / CLK_PERIOD), 32'(exp_clks));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int r0, f0;
    logic [31:0] held;
    rst_n = 1'b0;
    cmd_wr = 1'b0;
    cmd_wdata = '0;
    mdc_half = DIV_W'(3);
    repeat (4) @(negedge clk);
    check(cmd_rdata == 32'h0, "R1", "command after reset", cmd_rdata, 0);
    check(!busy && !mdc && !mdio_oe, "R1", "busy/mdc/oe after reset",
          {29'h0, busy, mdc, mdio_oe}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Clause 22 write
    r0 = mdc_rises;
    issue(mk(5'd3, 5'd5, 2'd1, 2'd1, 16'hA5C3), 16'hA5C3, "R10");
    check(mdc_rises - r0 == 64, "R4", "MDC periods per frame", 32'(mdc_rises - r0), 64);
    check(h_st == 2'b01 && h_op == 2'b01, "R4", "start/op on wire", {28'h0, h_st, h_op}, 32'h5);
    check(h_port == 5'd5 && h_dev == 5'd3, "R4", "port/reg on wire", {22'h0, h_port, h_dev}, {22'h0, 5'd5, 5'd3});
    check(h_ta == 2'b10 && h_data == 16'hA5C3, "R7", "turnaround and payload",
          {14'h0, h_ta, h_data}, {14'h0, 2'b10, 16'hA5C3});
    check(wr_gap == 0, "R7", "write frame released line", 32'(wr_gap), 0);

    // write during busy is ignored
    f0 = frames_seen;
    held = mk(5'd4, 5'd5, 2'd1, 2'd1, 16'h0F0F);
    fork
      issue(held, 16'h0F0F, "R3");
      begin
        wait (busy === 1'b1);
        repeat (20) @(negedge clk);
        cmd_wdata = mk(5'd4, 5'd5, 2'd1, 2'd1, 16'h1111);
        cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
        @(negedge clk);
        check(cmd_rdata == held, "R3", "register held during frame", cmd_rdata, held);
      end
    join
    repeat (4) @(negedge clk);
    check(frames_seen - f0 == 1, "R3", "frames produced", 32'(frames_seen - f0), 1);

    // Clause 22 reads with period measurement
    fork
      issue(mk(5'd3, 5'd5, 2'd2, 2'd1, 16'h0), 16'hA5C3, "R8");
      measure_period(8, "R5");
    join
    mdc_half = DIV_W'(1);
    fork
      issue(mk(5'd4, 5'd5, 2'd2, 2'd1, 16'h0), 16'h0F0F, "R3");
      measure_period(4, "R5");
    join
    check(conflicts == 0, "R8", "line contention on read", 32'(conflicts), 0);
    check(!mdc, "R5", "MDC low when idle", {31'h0, mdc}, 0);

    // Clause 45 sequences
    issue(mk(5'd1, 5'd2, 2'd0, 2'd0, 16'h0010), 16'h0010, "R10");
    check(h_st == 2'b00 && h_op == 2'b00, "R4", "Clause 45 address header", {28'h0, h_st, h_op}, 0);
    issue(mk(5'd1, 5'd2, 2'd1, 2'd0, 16'hBEEF), 16'hBEEF, "R9");
    issue(mk(5'd1, 5'd2, 2'd0, 2'd0, 16'h0020), 16'h0020, "R9");
    issue(mk(5'd1, 5'd2, 2'd1, 2'd0, 16'h1234), 16'h1234, "R9");
    issue(mk(5'd1, 5'd2, 2'd0, 2'd0, 16'h0010), 16'h0010, "R9");
    issue(mk(5'd1, 5'd2, 2'd3, 2'd0, 16'h0), 16'hBEEF, "R9");
    issue(mk(5'd1, 5'd2, 2'd0, 2'd0, 16'h0020), 16'h0020, "R9");
    issue(mk(5'd1, 5'd2, 2'd3, 2'd0, 16'h0), 16'h1234, "R9");
    check(conflicts == 0, "R8", "line contention on Clause 45 read", 32'(conflicts), 0);
    check(edge_viol == 0, "R6", "MDIO changes tied to MDC fall", 32'(edge_viol), 0);
    check(exp_q.size() == 0, "R2", "all commands completed", 32'(exp_q.size()), 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule